// File: doc/BRIEF.md
# Pixel shifter load controller

This block turns a byte of character pixels into a serial video bit stream for a video generator in which the CPU fetches the pixel data itself. A load request comes from decoding the CPU's opcode-fetch cycle. It is active low, and its width depends on how quickly the CPU bus settles. A width that varies like this cannot safely drive a shift register's load control directly. If it is too short, the register misses the load edge. If it is too long, it may see two edges.

The controller first passes the raw request through a synchroniser on the pixel clock, which runs at about 6.144 MHz. It then detects the falling edge of the synchronised request. From that edge it produces a single pixel-clock-wide, active-low load enable. A non-retriggerable hold window opens at the same moment and runs for a fixed number of pixel clocks. While the window is open, further request edges are dropped and latched into a sticky overrun flag.

The shift register takes the new byte in place of a shift on the load cycle. It then shifts one pixel out per pixel clock, most significant bit first, and fills with zeros behind the data. In normal use a new byte arrives every eight pixels, which gives a seamless stream.

Top module: `pixload_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears the shift register, drives `video_out` to 0, clears `overrun_err` and returns the hold window to its armed state.
- R2: A falling edge on `load_req_n` is taken as a request. The request is captured when `load_req_n` is low at clock edge k and was seen high by the synchroniser before that edge. `pix_data` is then loaded at edge k+3, so bit 7 of `pix_data` appears on `video_out` after edge k+3. The data must be stable over edges k+2 and k+3.
- R3: On each edge after a load that carries no new load, the register shifts toward bit 7, so bits 6 down to 0 follow on successive cycles. After the eighth bit, `video_out` is 0 until the next load.
- R4: Each accepted request loads exactly once, whether `load_req_n` stays low for 1 cycle or for 20 cycles. The later rise of `load_req_n` never loads.
- R5: A load that arrives while earlier bits are still being shifted out replaces them at once. The register takes the new byte on the load edge instead of shifting.
- R6: A request edge reaches the hold window HOLD_CYC or fewer cycles after the previous accepted edge (default 4) is dropped: the byte being shifted continues unchanged. An edge reaching it HOLD_CYC+1 cycles after the accepted one is accepted.
- R7: A dropped request sets `overrun_err` to 1. The flag stays at 1 until reset.
- R8: Requests eight cycles apart produce a continuous stream of 16 bits, with no gap and no repeated bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_data | input | 8 | Pixel byte from the character ROM read |
| load_req_n | input | 1 | Raw load request from the CPU cycle decode, active low, falling edge significant |
| video_out | output | 1 | Serial pixel bit, most significant bit first |
| overrun_err | output | 1 | Sticky flag: a request was dropped inside the hold window |

## Verification
The checks take it that `pix_data` holds still over the two edges around the load. They also take it that a request's low phase is seen by the synchroniser for at least one full cycle, with a high phase before it. The stimulus changes `pix_data` and `load_req_n` only on falling clock edges. Each request is kept low for at least one whole cycle and released before the next one falls. A new byte is placed on the bus only at, or after, the edge that loads the previous byte.

// File: rtl/pixload_pkg.sv
package pixload_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic {
        WIN_ARMED = 1'b0,
        WIN_HOLD  = 1'b1
    } win_state_e;

    // Control handed from the window logic to the shift register.
    typedef struct packed {
        logic load_n;
        pix_t data;
    } shift_cmd_t;

    function automatic logic edge_fell(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/pixload_sync.sv
module pixload_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/pixload_window.sv
module pixload_window
    import pixload_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_sync_n,
    output logic load_n,
    output logic overrun_err
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    win_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           prev_q;
    logic           fall;

    assign fall = edge_fell(prev_q, req_sync_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= WIN_ARMED;
            cnt_q       <= '0;
            prev_q      <= 1'b1;
            load_n      <= 1'b1;
            overrun_err <= 1'b0;
        end else begin
            prev_q <= req_sync_n;
            load_n <= 1'b1;
            case (state_q)
                WIN_ARMED: begin
                    if (fall) begin
                        state_q <= WIN_HOLD;
                        cnt_q   <= CW'(HOLD_CYC - 1);
                        load_n  <= 1'b0;
                    end
                end
                WIN_HOLD: begin
                    if (fall) overrun_err <= 1'b1;
                    if (cnt_q == '0) state_q <= WIN_ARMED;
                    else             cnt_q   <= cnt_q - CW'(1);
                end
                default: state_q <= WIN_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/pixload_shifter.sv
module pixload_shifter
    import pixload_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shift_cmd_t cmd,
    output pix_t       sr_q,
    output logic       bit_out
);
    always_ff @(posedge clk) begin
        if (rst)              sr_q <= '0;
        else if (!cmd.load_n) sr_q <= cmd.data;
        else                  sr_q <= {sr_q[PIX_W-2:0], 1'b0};
    end

    assign bit_out = sr_q[PIX_W-1];
endmodule

// File: rtl/pixload_ctrl.sv
module pixload_ctrl
    import pixload_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PIX_W-1:0]      pix_data,
    input  logic                  load_req_n,
    output logic                  video_out,
    output logic                  overrun_err
);
    logic       req_sync_n;
    logic       load_n;
    pix_t       sr_q;
    shift_cmd_t cmd;

    pixload_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (load_req_n),
        .d_out (req_sync_n)
    );

    pixload_window #(.HOLD_CYC(HOLD_CYC)) u_window (
        .clk         (clk),
        .rst         (rst),
        .req_sync_n  (req_sync_n),
        .load_n      (load_n),
        .overrun_err (overrun_err)
    );

    assign cmd.load_n = load_n;
    assign cmd.data   = pix_data;

    pixload_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .sr_q    (sr_q),
        .bit_out (video_out)
    );
endmodule

// File: rtl/pixload_ctrl_chk.sv
module pixload_ctrl_chk #(
    parameter int HOLD_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] pix_data,
    input logic       load_n,
    input logic [7:0] sr_q,
    input logic       video_out,
    input logic       overrun_err
);
    logic rst_seen_q = 1'b0;
    int   gap_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst)                 gap_q <= HOLD_CYC;
        else if (!load_n)        gap_q <= 0;
        else if (gap_q < 1000)   gap_q <= gap_q + 1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_seen_q |-> (!video_out && !overrun_err && load_n));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n) |=> (video_out == $past(pix_data[7])));

    // R3
    shift_order_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n) |=> (video_out == $past(sr_q[6])));

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n) |=> load_n);

    // R6
    load_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n) |-> (gap_q >= HOLD_CYC));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_err |=> overrun_err);
endmodule

bind pixload_ctrl pixload_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_data    (pix_data),
    .load_n      (load_n),
    .sr_q        (sr_q),
    .video_out   (video_out),
    .overrun_err (overrun_err)
);

// File: tb/test_pixload_ctrl.sv
module test_pixload_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_data = 8'h00;
    logic       load_req_n = 1'b1;
    logic       video_out;
    logic       overrun_err;

    pixload_ctrl #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) i_pixload_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pix_data    (pix_data),
        .load_req_n  (load_req_n),
        .video_out   (video_out),
        .overrun_err (overrun_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    v;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d got=%0d exp=%0d", tag, cyc, got, expv);
        end
    endtask

    // Monitor: pops expected bits as their cycle arrives.
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                check(1'b0, sb[0].tag, -1, int'(sb[0].v));
                void'(sb.pop_front());
            end
            if (sb.size() > 0 && sb[0].at == cyc) begin
                check(video_out == sb[0].v, sb[0].tag, int'(video_out), int'(sb[0].v));
                void'(sb.pop_front());
            end
        end
    end

    task automatic push_bits(input int start, input logic [7:0] d, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.at  = start + i;
            e.v   = d[7-i];
            e.tag = (i == 0) ? "R2" : tag;
            sb.push_back(e);
        end
    endtask

    task automatic push_zeros(input int start, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.at  = start + i;
            e.v   = 1'b0;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge: drive data and drop the request.
    task automatic start_req(input logic [7:0] d, output int c);
        pix_data   = d;
        load_req_n = 1'b0;
        c          = cyc;
    endtask

    task automatic end_req();
        load_req_n = 1'b1;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        idle(HOLD + 4);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int c;
        int c2;
        idle(3);
        rst = 1'b0;
        idle(1);
        check(video_out == 1'b0, "R1", int'(video_out), 0);
        check(overrun_err == 1'b0, "R1", int'(overrun_err), 0);

        // One-cycle request
        start_req(8'hA5, c);
        push_bits(c + 4, 8'hA5, 8, "R3");
        push_zeros(c + 12, 6, "R3");
        idle(1); end_req();
        drain();

        // Twenty-cycle request: one load, release does nothing
        start_req(8'h3C, c);
        push_bits(c + 4, 8'h3C, 8, "R4");
        push_zeros(c + 12, 20, "R4");
        idle(20); end_req();
        drain();

        // Two bytes eight cycles apart
        start_req(8'hF0, c);
        push_bits(c + 4, 8'hF0, 8, "R8");
        idle(1); end_req(); idle(7);
        start_req(8'h0F, c2);
        check(c2 == c + 8, "R8", c2 - c, 8);
        push_bits(c2 + 4, 8'h0F, 8, "R8");
        push_zeros(c2 + 12, 4, "R8");
        idle(1); end_req();
        drain();
        check(overrun_err == 1'b0, "R8", int'(overrun_err), 0);

        // Earliest accepted spacing: second byte cuts the first
        start_req(8'hFF, c);
        push_bits(c + 4, 8'hFF, HOLD + 1, "R5");
        idle(1); end_req(); idle(HOLD);
        start_req(8'h81, c2);
        push_bits(c2 + 4, 8'h81, 8, "R5");
        push_zeros(c2 + 12, 4, "R5");
        idle(1); end_req();
        drain();
        check(overrun_err == 1'b0, "R6", int'(overrun_err), 0);

        // Spacing inside the window: second request dropped
        start_req(8'h96, c);
        push_bits(c + 4, 8'h96, 8, "R6");
        push_zeros(c + 12, 6, "R6");
        idle(1); end_req(); idle(HOLD - 1);
        start_req(8'h69, c2);
        idle(1); end_req();
        drain();
        check(overrun_err == 1'b1, "R7", int'(overrun_err), 1);
        idle(10);
        check(overrun_err == 1'b1, "R7", int'(overrun_err), 1);

        // Reset clears the flag and output
        rst = 1'b1;
        idle(2);
        check(overrun_err == 1'b0, "R1", int'(overrun_err), 0);
        check(video_out == 1'b0, "R1", int'(video_out), 0);
        rst = 1'b0;
        idle(2);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog cyc=%0d got=hung exp=done", cyc);
            summary();
            $finish;
        end
    end
endmodule